// File: doc/BRIEF.md
# Parallel-Path Timing NCO with Sample Skip

This block is the phase accumulator of a symbol timing loop in a receiver that samples slightly faster than two samples per symbol and handles two samples on every clock. Each clock it adds a loop correction and a programmed drift term to a fractional phase. It then presents that phase to the interpolator as the fractional delay `mu`, together with a `skip` flag that tells the datapath to drop one sample.

Because two samples arrive per clock, a normal cycle advances the phase by the correction plus twice the drift. A cycle that follows an overflow advances it by the correction plus a single drift step. When the running sum crosses one, the integer bit raises `skip` and the integer part is removed, so the phase stays in [0,1). When the loop filter output is not valid, `en` is held low. The correction then counts as zero and only the drift moves the phase.

Top module: `skip_nco`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `mu` reads 0 and `skip` reads 0.
- R2: With `skip` low, the next phase is the current phase plus `p2` plus twice `dmu`, provided that sum is in [0,1). `skip` then stays low.
- R3: With `skip` high, the next phase is the current phase plus `p2` plus one `dmu`. Only a single drift step is taken.
- R4: If the sum is at least 1.0 and below 2.0, `skip` rises on the next clock and the stored phase becomes the sum minus 1.0.
- R5: A sum below zero stores a phase of exactly 0 and clears `skip`.
- R6: When `en` is low, the value on `p2` has no effect. Only the drift term moves the phase.
- R7: A sum of 2.0 or more stores the largest fraction (all ones) and raises `skip`.
- R8: The phase has FRAC_W fractional bits, with 1.0 = 2^FRAC_W. `p2` and `dmu` are two's complement in the same scale, FRAC_W+2 bits wide. `mu` is the top MU_W fractional bits of the phase, truncated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per pair of samples |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Loop correction valid; when low, `p2` is ignored |
| p2 | input | FRAC_W+2 | Signed loop-filter correction |
| dmu | input | FRAC_W+2 | Signed per-sample drift term |
| mu | output | MU_W | Truncated fractional delay for the interpolator |
| skip | output | 1 | Drop one sample in this cycle |

## Verification
The assertions compute the candidate sum from `p2`, `dmu`, `en` and the present `skip` in 32-bit arithmetic. They take for granted that the inputs are stable around the clock edge and small enough not to overflow that range. The bench changes inputs only at falling edges and keeps every value well inside the input width. Most steps land the sum in [0,1) or [1,2). Dedicated steps push it below zero, to exactly 2.0, and to a value whose low bits fall under the `mu` truncation.

// File: rtl/skip_nco.sv
module skip_nco #(
  parameter int FRAC_W = 16,
  parameter int MU_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [FRAC_W+1:0] p2,
  input  logic signed [FRAC_W+1:0] dmu,
  output logic [MU_W-1:0]          mu,
  output logic                     skip
);
  localparam int IN_W = FRAC_W + 2;
  localparam int SW   = FRAC_W + 4;

  logic [FRAC_W-1:0] acc;
  logic [FRAC_W-1:0] acc_nxt;
  logic              skip_nxt;

  wire signed [SW-1:0] acc_x  = {{(SW-FRAC_W){1'b0}}, acc};
  wire signed [SW-1:0] p2_x   = en ? {{(SW-IN_W){p2[IN_W-1]}}, p2} : '0;
  wire signed [SW-1:0] dmu_x  = {{(SW-IN_W){dmu[IN_W-1]}}, dmu};
  wire signed [SW-1:0] step_x = skip ? dmu_x : (dmu_x <<< 1);
  wire signed [SW-1:0] sum    = acc_x + p2_x + step_x;

  wire below_zero = sum[SW-1];
  wire at_two     = |sum[SW-2:FRAC_W+1];
  wire at_one     = sum[FRAC_W];

  always_comb begin
    acc_nxt  = sum[FRAC_W-1:0];
    skip_nxt = at_one;
    if (below_zero) begin
      acc_nxt  = '0;
      skip_nxt = 1'b0;
    end else if (at_two) begin
      acc_nxt  = '1;
      skip_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      skip <= 1'b0;
    end else begin
      acc  <= acc_nxt;
      skip <= skip_nxt;
    end
  end

  assign mu = acc[FRAC_W-1 -: MU_W];
endmodule

// File: rtl/skip_nco_chk.sv
module skip_nco_chk #(
  parameter int FRAC_W = 16,
  parameter int MU_W   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     en,
  input logic signed [FRAC_W+1:0] p2,
  input logic signed [FRAC_W+1:0] dmu,
  input logic [FRAC_W-1:0]        acc,
  input logic [MU_W-1:0]          mu,
  input logic                     skip
);
  localparam int ONE = 1 << FRAC_W;
  localparam int TWO = 2 << FRAC_W;

  int s_now;
  always_comb s_now = int'(acc) + (en ? int'(p2) : 0) + (skip ? 1 : 2) * int'(dmu);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (acc == '0 && !skip && mu == '0)); // R1
  AST_STEP_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!skip && s_now >= 0 && s_now < ONE) |=> (!skip && int'(acc) == $past(s_now))); // R2
  AST_STEP_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (skip && s_now >= 0 && s_now < ONE) |=> (int'(acc) == $past(s_now))); // R3
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (s_now >= ONE && s_now < TWO) |=> (skip && int'(acc) == $past(s_now) - ONE)); // R4
  AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (s_now < 0) |=> (acc == '0 && !skip)); // R5
  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (s_now >= TWO) |=> (skip && &acc)); // R7
endmodule

bind skip_nco skip_nco_chk #(.FRAC_W(FRAC_W), .MU_W(MU_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .p2(p2), .dmu(dmu),
  .acc(acc), .mu(mu), .skip(skip)
);

// File: tb/sim_skip_nco.sv
`timescale 1ns/1ps
module sim_skip_nco;
  localparam int FRAC_W = 16;
  localparam int MU_W   = 8;
  localparam int IN_W   = FRAC_W + 2;
  localparam int ONE    = 1 << FRAC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic signed [IN_W-1:0] p2 = '0;
  logic signed [IN_W-1:0] dmu = '0;
  logic [MU_W-1:0] mu;
  logic skip;

  int n_run = 0;
  int n_fail = 0;
  int m_acc = 0;
  int m_skip = 0;

  always #2.5 clk = ~clk;

  skip_nco #(.FRAC_W(FRAC_W), .MU_W(MU_W)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .p2(p2), .dmu(dmu), .mu(mu), .skip(skip)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; p2 = '0; dmu = '0;
    @(posedge clk); @(posedge clk); #1;
    m_acc = 0; m_skip = 0;
    check("R1 mu in reset", int'(mu), 0);
    check("R1 skip in reset", int'(skip), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input string tag, input int p, input int d, input bit e);
    int s;
    @(negedge clk);
    p2 = IN_W'(p); dmu = IN_W'(d); en = e;
    @(posedge clk); #1;
    s = m_acc + (e ? p : 0) + (m_skip ? 1 : 2) * d;
    if (s < 0) begin m_acc = 0; m_skip = 0; end
    else if (s >= 2 * ONE) begin m_acc = ONE - 1; m_skip = 1; end
    else if (s >= ONE) begin m_acc = s - ONE; m_skip = 1; end
    else begin m_acc = s; m_skip = 0; end
    check({tag, " mu"}, int'(mu), m_acc >> (FRAC_W - MU_W));
    check({tag, " skip"}, int'(skip), m_skip);
  endtask

  task automatic t_reset();
    do_reset();
    @(posedge clk); #1;
    check("R1 mu after release", int'(mu), 0);
    check("R1 skip after release", int'(skip), 0);
  endtask

  task automatic t_normal();
    do_reset();
    for (int i = 0; i < 5; i++) step("R2 normal step", 0, 'h300, 1'b1);
    check("R2 mu after five steps", int'(mu), 'h1E);
    step("R2 with correction", 'h1000, 'h100, 1'b1);
  endtask

  task automatic t_skip();
    do_reset();
    for (int i = 0; i < 3; i++) step("R4 approach", 0, 'h2000, 1'b1);
    step("R4 wrap", 0, 'h2000, 1'b1);
    check("R4 wrap skip", int'(skip), 1);
    check("R4 wrap mu", int'(mu), 0);
    step("R3 single drift", 0, 'h2000, 1'b1);
    check("R3 single drift mu", int'(mu), 'h20);
    check("R3 skip cleared", int'(skip), 0);
    step("R4 wrap with correction", 'hE000, 'h1000, 1'b1);
    step("R3 correction in skip cycle", 'h0400, 'h1000, 1'b1);
  endtask

  task automatic t_clamp();
    do_reset();
    step("R5 clamp from zero", -'h4000, 0, 1'b1);
    check("R5 clamp mu", int'(mu), 0);
    step("R5 rise", 'h8000, 0, 1'b1);
    step("R5 clamp from half", -'h10000, 'h100, 1'b1);
    check("R5 clamp from half mu", int'(mu), 0);
  endtask

  task automatic t_enable();
    do_reset();
    step("R6 p2 ignored", 'h8000, 'h100, 1'b0);
    check("R6 drift only", int'(mu), 2);
    step("R6 negative p2 ignored", -'h8000, 'h100, 1'b0);
    check("R6 drift only again", int'(mu), 4);
  endtask

  task automatic t_sat();
    do_reset();
    step("R7 load", 'hF000, 0, 1'b1);
    step("R7 saturate", 'hF000, 'h1000, 1'b1);
    check("R7 saturate mu", int'(mu), 'hFF);
    check("R7 saturate skip", int'(skip), 1);
  endtask

  task automatic t_trunc();
    do_reset();
    step("R8 trunc a", 'h7F, 'h80, 1'b1);
    check("R8 mu floor a", int'(mu), 1);
    step("R8 trunc b", 'h7F, 'h80, 1'b1);
    check("R8 mu floor b", int'(mu), 2);
    step("R8 trunc c", 'h7F, 'h80, 1'b1);
    check("R8 mu floor c", int'(mu), 4);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_skip();
    t_clamp();
    t_enable();
    t_sat();
    t_trunc();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule